// File: doc/BRIEF.md
# External-Trigger Timer Slave Controller

This block is an up-counter whose progress is steered by one external trigger line. The line is first brought into the clock domain by a synchroniser, then given a polarity, then qualified by a trigger-source selector. A slave-mode field decides what the qualified trigger does to the counter. In restart mode, each active edge returns the counter to zero, and counting then continues from there. In gated mode, the counter advances only while the trigger sits at its active level. Any other mode value leaves a plain free-running counter that only the count enable controls. In every mode the counter wraps from the auto-reload value back to zero.

Each trigger event sets a sticky flag. Software clears the flag with a one-cycle write-1-to-clear strobe. The flag produces an interrupt request and a DMA request, each with its own enable. The block is meant to sit behind a register file that supplies the mode, select, polarity, enable and reload values as static levels.

Top module: `tmr_slave_ctl`

## Requirements
- R1: When `slave_mode` is neither 3'b100 nor 3'b101, the counter adds one on each clock while `cnt_en` is 1 and holds while `cnt_en` is 0. From the value `arr` it goes to 0 on the next counting clock.
- R2: With `slave_mode` = 3'b100, an active trigger edge loads 0 into the counter. Counting then resumes from 0 on the following clocks at one step per clock.
- R3: Suppose the trigger line changes between two clock edges, and call the next rising edge the first. With the default two synchroniser stages, the clear and the flag update both take effect at the third rising edge, and the counter still counts at the first two.
- R4: With `trig_pol` = 0 the rising edge of the line is the active edge and the high level is the active level. With `trig_pol` = 1 the falling edge is active and the low level is active. An edge of the opposite direction neither clears the counter nor sets the flag.
- R5: With `slave_mode` = 3'b101, the counter advances only on clocks where the synchronised trigger is at its active level and `cnt_en` is 1. Otherwise it holds its value. With `cnt_en` = 0 it holds whatever the trigger level.
- R6: Only `trig_sel` = 5'b00101 connects the trigger line. For every other select value the trigger is treated as never active: no clear, a closed gate and no flag.
- R7: In restart or gated mode, each change of the synchronised trigger into its active state sets `trig_flag`. The flag stays set until `flag_clr` is 1 at a clock edge. If a trigger event and `flag_clr` meet at the same edge, the flag stays set. In free-running mode the flag is never set.
- R8: `irq_req` is 1 exactly while `trig_flag` and `irq_en` are both 1. `dma_req` is 1 exactly while `trig_flag` and `dma_en` are both 1.
- R9: While `rst_n` is 0, the counter reads 0 and the flag and both requests read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Raw external trigger line, asynchronous |
| trig_pol | input | 1 | 0: rising edge / high level active; 1: falling edge / low level active |
| slave_mode | input | 3 | 3'b100 restart, 3'b101 gated, other values free-running |
| trig_sel | input | 5 | Trigger source select; 5'b00101 connects `trig_in` |
| cnt_en | input | 1 | Counter enable |
| arr | input | CNT_W | Auto-reload (wrap) value |
| irq_en | input | 1 | Interrupt request enable |
| dma_en | input | 1 | DMA request enable |
| flag_clr | input | 1 | Write-1-to-clear strobe for the trigger flag |
| cnt_q | output | CNT_W | Counter value |
| trig_flag | output | 1 | Sticky trigger flag |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench measures the restart latency edge by edge. A design with one synchroniser stage too few or too many shows the counter cleared one sample early or late. The bench reverses the polarity in both trigger modes and feeds the inactive edge direction. A design that swaps edge and level sense clears the counter on the wrong edge, or gates the count open when it should be closed. It also runs the counter through the auto-reload wrap and holds `cnt_en` low in gated mode with the gate open, where an off-by-one compare or a gate that ignores the enable shows up as a wrong count. Finally it applies a non-matching trigger select, and it lands a flag clear on the same edge as a new trigger, where a clear-wins flag would read 0.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;

   localparam logic [2:0] SMODE_RESTART = 3'b100;
   localparam logic [2:0] SMODE_GATED   = 3'b101;
   localparam logic [4:0] TSEL_LINE     = 5'b00101;

   typedef enum logic [1:0] {
      OP_FREE    = 2'd0,
      OP_RESTART = 2'd1,
      OP_GATED   = 2'd2
   } op_mode_e;

   function automatic op_mode_e decode_mode(input logic [2:0] sm);
      op_mode_e m;
      case (sm)
         SMODE_RESTART: m = OP_RESTART;
         SMODE_GATED:   m = OP_GATED;
         default:       m = OP_FREE;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tmr_trig_cond.sv
module tmr_trig_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_sync,
   input  logic pol,
   input  logic sel_ok,
   output logic act,
   output logic evt
);

   logic act_d;

   assign act = sel_ok & (lvl_sync ^ pol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_d <= 1'b0;
      else        act_d <= act;
   end

   assign evt = act & ~act_d;

endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [CNT_W-1:0] arr,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic             at_top;
   logic [CNT_W-1:0] cnt_nx;

   assign at_top = (cnt_q == arr);

   always_comb begin
      cnt_nx = cnt_q;
      if (clr)         cnt_nx = ZERO;
      else if (run) begin
         if (at_top)   cnt_nx = ZERO;
         else          cnt_nx = cnt_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= ZERO;
      else        cnt_q <= cnt_nx;
   end

endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic irq_en,
   input  logic dma_en,
   output logic flag,
   output logic irq_req,
   output logic dma_req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (set)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

   assign irq_req = flag & irq_en;
   assign dma_req = flag & dma_en;

endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
   import tmr_slave_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   input  logic             trig_pol,
   input  logic [2:0]       slave_mode,
   input  logic [4:0]       trig_sel,
   input  logic             cnt_en,
   input  logic [CNT_W-1:0] arr,
   input  logic             irq_en,
   input  logic             dma_en,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             trig_flag,
   output logic             irq_req,
   output logic             dma_req
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tmr_slave_ctl: CNT_W must lie in 2..32");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("tmr_slave_ctl: SYNC_STAGES must lie in 2..4");
      end
   endgenerate

   op_mode_e op;
   logic     lvl_sync;
   logic     sel_ok;
   logic     trig_act;
   logic     trig_evt;
   logic     cnt_clr;
   logic     cnt_run;
   logic     flag_set;

   assign op     = decode_mode(slave_mode);
   assign sel_ok = (trig_sel == TSEL_LINE);

   tmr_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (trig_in),
      .q     (lvl_sync)
   );

   tmr_trig_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_sync (lvl_sync),
      .pol      (trig_pol),
      .sel_ok   (sel_ok),
      .act      (trig_act),
      .evt      (trig_evt)
   );

   always_comb begin
      cnt_clr  = 1'b0;
      cnt_run  = cnt_en;
      flag_set = 1'b0;
      case (op)
         OP_RESTART: begin
            cnt_clr  = trig_evt;
            flag_set = trig_evt;
         end
         OP_GATED: begin
            cnt_run  = cnt_en & trig_act;
            flag_set = trig_evt;
         end
         default: ;
      endcase
   end

   tmr_cnt_core #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .run   (cnt_run),
      .arr   (arr),
      .cnt_q (cnt_q)
   );

   tmr_flag_ctl u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (flag_set),
      .clr     (flag_clr),
      .irq_en  (irq_en),
      .dma_en  (dma_en),
      .flag    (trig_flag),
      .irq_req (irq_req),
      .dma_req (dma_req)
   );

endmodule

// File: rtl/tmr_slave_ctl_chk.sv
module tmr_slave_ctl_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       slave_mode,
   input logic             cnt_en,
   input logic [CNT_W-1:0] arr,
   input logic             irq_en,
   input logic             dma_en,
   input logic             flag_clr,
   input logic [CNT_W-1:0] cnt_q,
   input logic             trig_flag,
   input logic             irq_req,
   input logic             dma_req
);

   logic is_free;
   logic is_gated;
   assign is_free  = (slave_mode != 3'b100) && (slave_mode != 3'b101);
   assign is_gated = (slave_mode == 3'b101);

   // R1
   free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_free && cnt_en && cnt_q == arr) |=> (cnt_q == '0));

   // R1
   free_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_free && !cnt_en) |=> $stable(cnt_q));

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == '0));

   // R5
   gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_gated && !cnt_en) |=> $stable(cnt_q));

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_flag && !flag_clr) |=> trig_flag);

   // R8
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (trig_flag && irq_en));

   // R8
   dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (trig_flag && dma_en));

endmodule

bind tmr_slave_ctl tmr_slave_ctl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slave_mode (slave_mode),
   .cnt_en     (cnt_en),
   .arr        (arr),
   .irq_en     (irq_en),
   .dma_en     (dma_en),
   .flag_clr   (flag_clr),
   .cnt_q      (cnt_q),
   .trig_flag  (trig_flag),
   .irq_req    (irq_req),
   .dma_req    (dma_req)
);

// File: tb/tmr_slave_ctl_bench.sv
module tmr_slave_ctl_bench;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig_in = 1'b0;
   logic          trig_pol = 1'b0;
   logic [2:0]    slave_mode = 3'b000;
   logic [4:0]    trig_sel = 5'b00101;
   logic          cnt_en = 1'b0;
   logic [CW-1:0] arr = 16'h0036;
   logic          irq_en = 1'b0;
   logic          dma_en = 1'b0;
   logic          flag_clr = 1'b0;
   logic [CW-1:0] cnt_q;
   logic          trig_flag;
   logic          irq_req;
   logic          dma_req;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   tmr_slave_ctl u_tmr_slave_ctl (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_pol(trig_pol),
      .slave_mode(slave_mode), .trig_sel(trig_sel), .cnt_en(cnt_en), .arr(arr),
      .irq_en(irq_en), .dma_en(dma_en), .flag_clr(flag_clr),
      .cnt_q(cnt_q), .trig_flag(trig_flag), .irq_req(irq_req), .dma_req(dma_req)
   );

   typedef struct packed {
      logic [2:0]  mode;
      logic        pol;
      logic [4:0]  sel;
      logic        en;
      logic        trig;
      logic        clr;
      logic [7:0]  ncyc;
      logic [15:0] exp_cnt;
      logic        exp_flag;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t TBL [NV] = '{
      '{3'b000, 1'b0, 5'b00101, 1'b1, 1'b0, 1'b0, 8'd10, 16'd10, 1'b0, 4'd1}, // R1 free count
      '{3'b000, 1'b0, 5'b00101, 1'b0, 1'b0, 1'b0, 8'd5,  16'd10, 1'b0, 4'd1}, // R1 hold
      '{3'b000, 1'b0, 5'b00101, 1'b1, 1'b0, 1'b0, 8'd44, 16'd54, 1'b0, 4'd1}, // R1 reach arr
      '{3'b000, 1'b0, 5'b00101, 1'b1, 1'b0, 1'b0, 8'd1,  16'd0,  1'b0, 4'd1}, // R1 wrap
      '{3'b000, 1'b0, 5'b00101, 1'b1, 1'b0, 1'b0, 8'd3,  16'd3,  1'b0, 4'd1}, // R1
      '{3'b100, 1'b0, 5'b00101, 1'b1, 1'b1, 1'b0, 8'd2,  16'd5,  1'b0, 4'd3}, // R3 not yet cleared
      '{3'b100, 1'b0, 5'b00101, 1'b1, 1'b1, 1'b0, 8'd1,  16'd0,  1'b1, 4'd2}, // R2 cleared at third edge
      '{3'b100, 1'b0, 5'b00101, 1'b1, 1'b1, 1'b0, 8'd7,  16'd7,  1'b1, 4'd7}, // R7 sticky, resumes
      '{3'b100, 1'b0, 5'b00101, 1'b1, 1'b0, 1'b0, 8'd4,  16'd11, 1'b1, 4'd4}, // R4 falling ignored
      '{3'b100, 1'b0, 5'b00101, 1'b1, 1'b0, 1'b1, 8'd1,  16'd12, 1'b0, 4'd7}, // R7 clear
      '{3'b100, 1'b0, 5'b00101, 1'b1, 1'b1, 1'b0, 8'd3,  16'd0,  1'b1, 4'd2}, // R2 second restart
      '{3'b100, 1'b0, 5'b00101, 1'b1, 1'b1, 1'b1, 8'd1,  16'd1,  1'b0, 4'd7}, // R7 clear
      '{3'b100, 1'b1, 5'b00101, 1'b1, 1'b1, 1'b0, 8'd4,  16'd5,  1'b0, 4'd4}, // R4 inverted, high idle
      '{3'b100, 1'b1, 5'b00101, 1'b1, 1'b0, 1'b0, 8'd2,  16'd7,  1'b0, 4'd3}, // R3 falling pending
      '{3'b100, 1'b1, 5'b00101, 1'b1, 1'b0, 1'b0, 8'd1,  16'd0,  1'b1, 4'd4}, // R4 falling clears
      '{3'b100, 1'b1, 5'b00101, 1'b1, 1'b0, 1'b1, 8'd1,  16'd1,  1'b0, 4'd7}, // R7 clear
      '{3'b101, 1'b1, 5'b00101, 1'b1, 1'b0, 1'b0, 8'd5,  16'd6,  1'b0, 4'd5}, // R5 low gate open
      '{3'b101, 1'b1, 5'b00101, 1'b1, 1'b1, 1'b0, 8'd6,  16'd8,  1'b0, 4'd5}, // R5 gate closes late
      '{3'b101, 1'b1, 5'b00101, 1'b1, 1'b0, 1'b0, 8'd2,  16'd8,  1'b0, 4'd5}, // R5 reopen pending
      '{3'b101, 1'b1, 5'b00101, 1'b1, 1'b0, 1'b0, 8'd1,  16'd9,  1'b1, 4'd7}, // R7 gate open event
      '{3'b101, 1'b1, 5'b00101, 1'b0, 1'b0, 1'b0, 8'd4,  16'd9,  1'b1, 4'd5}, // R5 enable off holds
      '{3'b101, 1'b1, 5'b00101, 1'b1, 1'b0, 1'b1, 8'd1,  16'd10, 1'b0, 4'd7}, // R7 clear
      '{3'b100, 1'b0, 5'b00000, 1'b1, 1'b1, 1'b0, 8'd5,  16'd15, 1'b0, 4'd6}, // R6 wrong select
      '{3'b000, 1'b0, 5'b00000, 1'b1, 1'b0, 1'b1, 8'd3,  16'd18, 1'b0, 4'd1}  // R1
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R9 reset state
      repeat (2) @(negedge clk);
      check("R9 cnt", 32'(cnt_q), 32'd0);
      check("R9 flag", 32'(trig_flag), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         slave_mode = TBL[i].mode;
         trig_pol   = TBL[i].pol;
         trig_sel   = TBL[i].sel;
         cnt_en     = TBL[i].en;
         trig_in    = TBL[i].trig;
         flag_clr   = TBL[i].clr;
         ticks(int'(TBL[i].ncyc));
         flag_clr   = 1'b0;
         check($sformatf("R%0d vec%0d cnt", TBL[i].req, i), 32'(cnt_q), 32'(TBL[i].exp_cnt));
         check($sformatf("R%0d vec%0d flag", TBL[i].req, i), 32'(trig_flag), 32'(TBL[i].exp_flag));
      end

      // R9 reset in mid-run
      rst_n = 1'b0;
      irq_en = 1'b1;
      dma_en = 1'b1;
      ticks(2);
      check("R9 cnt mid-run", 32'(cnt_q), 32'd0);
      check("R9 irq", 32'(irq_req), 32'd0);
      check("R9 dma", 32'(dma_req), 32'd0);
      irq_en = 1'b0;
      dma_en = 1'b0;
      slave_mode = 3'b100;
      trig_pol = 1'b0;
      trig_sel = 5'b00101;
      trig_in = 1'b0;
      cnt_en = 1'b1;
      rst_n = 1'b1;
      ticks(3);
      check("R2 pre count", 32'(cnt_q), 32'd3);

      // R7 set wins over a clear strobe in the same cycle
      trig_in = 1'b1;
      ticks(2);
      flag_clr = 1'b1;
      ticks(1);
      flag_clr = 1'b0;
      check("R7 set beats clear", 32'(trig_flag), 32'd1);
      check("R2 cleared", 32'(cnt_q), 32'd0);
      check("R8 irq off", 32'(irq_req), 32'd0);
      check("R8 dma off", 32'(dma_req), 32'd0);
      irq_en = 1'b1;
      #1;
      check("R8 irq on", 32'(irq_req), 32'd1);
      check("R8 dma still off", 32'(dma_req), 32'd0);
      irq_en = 1'b0;
      dma_en = 1'b1;
      #1;
      check("R8 dma on", 32'(dma_req), 32'd1);
      check("R8 irq off again", 32'(irq_req), 32'd0);
      @(negedge clk);
      flag_clr = 1'b1;
      ticks(1);
      flag_clr = 1'b0;
      check("R7 cleared", 32'(trig_flag), 32'd0);
      check("R8 dma drops", 32'(dma_req), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule